// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Defined Corner Results

This block divides one W-bit integer by another over a fixed number of clock cycles. It can return either the quotient or the remainder, and it treats the operands as signed or unsigned. A caller presents the operands and a 2-bit operation code together with a one-cycle start strobe. When the answer is ready the block raises a one-cycle done pulse, and the registered result stays valid until the next completion.

Inside, the block uses a restoring shift-and-subtract loop. The divisor sits in the upper half of a double-width register and moves right one bit per step. The remainder register begins holding the dividend magnitude, and the quotient shifts in one bit per step. Signed operations divide the magnitudes and then correct the signs. A zero divisor and the single signed overflow case raise no error. Each returns a fixed value, so software never has to handle a trap.

Top module: `restoring_divider`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and done are low and result is zero.
- R2: Operation code bit 1 selects the output (0 quotient, 1 remainder) and bit 0 selects unsigned operands (1) or two's-complement operands (0). Codes: 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder. Unsigned results are the floor quotient and the matching remainder.
- R3: A signed quotient rounds toward zero, and it is negative exactly when the operand signs differ.
- R4: A signed remainder carries the sign of the dividend, with dividend = quotient × divisor + remainder.
- R5: With a zero divisor, both quotient codes return all ones.
- R6: With a zero divisor, both remainder codes return the dividend unchanged.
- R7: The signed case of the most negative value divided by −1 returns the dividend as the quotient and zero as the remainder.
- R8: done goes high on the (W+2)-th rising edge after the edge that accepts start, and it stays high for exactly one cycle.
- R9: A start is accepted only while busy is low. busy goes high on the accepting edge and stays high until done rises. A start strobe (with any operands) seen while busy is high has no effect on the result.
- R10: result changes only on the edge that raises done. A new start may be accepted in the same cycle that done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted when busy is low |
| op | input | 2 | Operation code: bit 1 remainder select, bit 0 unsigned select |
| dividend | input | W | Dividend, sampled on the accepting edge |
| divisor | input | W | Divisor, sampled on the accepting edge |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Registered quotient or remainder |

## Verification
Two events can land in the same cycle: the completion pulse of one division and the acceptance of the next start. The bench issues every new request at the negative edge where done is seen high, so the two always coincide. It then checks, one cycle later, that the previous result is still held and that done has dropped. The bench also repeats the start strobe with altered operands in the first busy cycle, and the final answer must still match the original request. All four operation codes are swept over every operand pair at a 5-bit width, which covers zero divisors and the overflow pair.

// File: rtl/rdiv_pkg.sv
`timescale 1ns/1ps
package rdiv_pkg;
  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } rdiv_op_e;

  typedef struct packed {
    logic want_rem;
    logic neg_quo;
    logic neg_rem;
    logic by_zero;
    logic ovf;
  } rdiv_ctx_t;
endpackage

// File: rtl/rdiv_prep.sv
`timescale 1ns/1ps
module rdiv_prep
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output rdiv_ctx_t    ctx
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic is_signed, a_neg, b_neg;

  always_comb begin
    is_signed    = ~op[0];
    a_neg        = is_signed & a[W-1];
    b_neg        = is_signed & b[W-1];
    mag_a        = a_neg ? (~a + 1'b1) : a;
    mag_b        = b_neg ? (~b + 1'b1) : b;
    ctx.want_rem = op[1];
    ctx.neg_quo  = a_neg ^ b_neg;
    ctx.neg_rem  = a_neg;
    ctx.by_zero  = (b == '0);
    ctx.ovf      = is_signed & (a == MOST_NEG) & (b == ALL_ONES);
  end
endmodule

// File: rtl/rdiv_core.sv
`timescale 1ns/1ps
module rdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic         run,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int STEPS = W + 1;
  localparam int CW    = $clog2(STEPS + 1);

  logic [2*W-1:0] dvs_q;
  logic [W-1:0]   rem_q, quo_q, sub;
  logic [CW-1:0]  cnt_q;
  logic           run_q, fin_q, fits;

  // The remainder can take the subtraction only when the shifted divisor
  // is no larger; then the divisor's upper half is zero and a W-bit
  // subtraction is exact.
  always_comb begin
    fits = ({{W{1'b0}}, rem_q} >= dvs_q);
    sub  = rem_q - dvs_q[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load) begin
        dvs_q <= {mag_b, {W{1'b0}}};
        rem_q <= mag_a;
        quo_q <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) rem_q <= sub;
        quo_q <= {quo_q[W-2:0], fits};
        dvs_q <= dvs_q >> 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(STEPS - 1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign run = run_q;
  assign fin = fin_q;
  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/rdiv_fix.sv
`timescale 1ns/1ps
module rdiv_fix
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fin,
  input  rdiv_ctx_t    ctx,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  output logic         done,
  output logic [W-1:0] result
);
  logic [W-1:0] q_s, r_s, pick;

  always_comb begin
    q_s = ctx.neg_quo ? (~quo + 1'b1) : quo;
    r_s = ctx.neg_rem ? (~rem + 1'b1) : rem;
    if (ctx.by_zero) begin
      q_s = '1;
      r_s = dvd;
    end else if (ctx.ovf) begin
      q_s = dvd;
      r_s = '0;
    end
    pick = ctx.want_rem ? r_s : q_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= fin;
      if (fin) result <= pick;
    end
  end
endmodule

// File: rtl/restoring_divider.sv
`timescale 1ns/1ps
module restoring_divider
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  logic [W-1:0] mag_a, mag_b, quo, rem, dvd_q;
  rdiv_ctx_t    ctx_in, ctx_q;
  logic         run, fin, accept;

  assign busy   = run | fin;
  assign accept = start & ~busy;

  rdiv_prep #(.W(W)) prep_i (
    .op(op), .a(dividend), .b(divisor),
    .mag_a(mag_a), .mag_b(mag_b), .ctx(ctx_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= '0;
      dvd_q <= '0;
    end else if (accept) begin
      ctx_q <= ctx_in;
      dvd_q <= dividend;
    end
  end

  rdiv_core #(.W(W)) core_i (
    .clk(clk), .rst(rst), .load(accept),
    .mag_a(mag_a), .mag_b(mag_b),
    .run(run), .fin(fin), .quo(quo), .rem(rem)
  );

  rdiv_fix #(.W(W)) fix_i (
    .clk(clk), .rst(rst), .fin(fin), .ctx(ctx_q), .dvd(dvd_q),
    .quo(quo), .rem(rem), .done(done), .result(result)
  );
endmodule

// File: rtl/rdiv_chk.sv
`timescale 1ns/1ps
module rdiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  localparam int LW = $clog2(W + 4) + 1;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [LW-1:0] lat_q;
  logic [W-1:0]  cap_a, cap_b;
  logic [1:0]    cap_op;
  logic          acc;

  assign acc = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
      cap_op <= '0;
    end else begin
      if (acc) begin
        lat_q  <= 1;
        cap_a  <= dividend;
        cap_b  <= divisor;
        cap_op <= op;
      end else if (done) begin
        lat_q <= '0;
      end else if (lat_q != 0) begin
        lat_q <= lat_q + 1'b1;
      end
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> lat_q == LW'(W + 3)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    acc |=> busy); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R10
  AST_DZ_QUOT: assert property (@(posedge clk) disable iff (rst)
    (done && cap_b == '0 && !cap_op[1]) |-> result == '1); // R5
  AST_DZ_REM: assert property (@(posedge clk) disable iff (rst)
    (done && cap_b == '0 && cap_op[1]) |-> result == cap_a); // R6
  AST_SIGNED_OVF: assert property (@(posedge clk) disable iff (rst)
    (done && !cap_op[0] && cap_a == MOST_NEG && cap_b == '1)
      |-> result == (cap_op[1] ? '0 : cap_a)); // R7
endmodule

bind restoring_divider rdiv_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .op(op), .dividend(dividend),
  .divisor(divisor), .busy(busy), .done(done), .result(result)
);

// File: tb/restoring_divider_tb_top.sv
`timescale 1ns/1ps
module restoring_divider_tb_top;
  localparam int W   = 5;
  localparam int LAT = W + 3; // negedges from driving start to seeing done

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = '0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] prev_exp = '0;
  bit           have_prev = 0;

  always #2.5 clk = ~clk;

  restoring_divider #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [1:0] o,
                                         input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    int ua, ub, sa, sb, q, r;
    ua = int'(a);
    ub = int'(b);
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (o[0]) begin
      if (ub == 0) begin q = -1; r = ua; end
      else begin q = ua / ub; r = ua % ub; end
    end else begin
      if (sb == 0) begin q = -1; r = sa; end
      else if (sa == -(1 << (W - 1)) && sb == -1) begin q = sa; r = 0; end
      else begin q = sa / sb; r = sa % sb; end
    end
    return o[1] ? W'(r) : W'(q);
  endfunction

  function automatic string tag(input logic [1:0] o, input logic [W-1:0] a,
                                input logic [W-1:0] b);
    if (b == '0) return o[1] ? "R6 zero-divisor remainder" : "R5 zero-divisor quotient";
    if (!o[0] && a == {1'b1, {(W-1){1'b0}}} && b == '1) return "R7 signed overflow";
    if (o[0]) return "R2 unsigned";
    return o[1] ? "R4 signed remainder" : "R3 signed quotient";
  endfunction

  // Called at a negedge where busy is low (possibly the done cycle of the
  // previous run: R10 back-to-back acceptance).
  task automatic run_one(input logic [1:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    int n;
    logic [W-1:0] exp;
    exp = model(o, a, b);
    start = 1'b1; op = o; dividend = a; divisor = b;
    @(negedge clk);
    n = 1;
    check("R9 busy after accept", W'(busy), W'(1));
    check("R8 done single cycle", W'(done), W'(0));
    if (have_prev) check("R10 result held", result, prev_exp);
    // R9: strobe again with different operands while busy; must be ignored
    start = 1'b1; op = ~o; dividend = ~a; divisor = b + 1'b1;
    @(negedge clk);
    n++;
    start = 1'b0;
    while (!done && n < LAT + 8) begin
      @(negedge clk);
      n++;
    end
    check("R8 latency", W'(n), W'(LAT));
    check(tag(o, a, b), result, exp);
    prev_exp  = exp;
    have_prev = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", W'(busy), W'(0));
    check("R1 done in reset", W'(done), W'(0));
    check("R1 result in reset", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", W'(busy), W'(0));
    check("R1 result after reset", result, '0);
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          run_one(2'(o), W'(a), W'(b));
    @(negedge clk);
    check("R8 done dropped", W'(done), W'(0));
    check("R10 final hold", result, prev_exp);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule